// File: doc/BRIEF.md
# Fail-Safe Field Output Controller

This block decides what the field outputs of a process controller are commanded to: a loop-current code for a 4–20 mA transmitter, a duty setting for a 0–10 V / PWM output and a set of relay/SSR enables. In normal operation it passes the control request through, with the loop code limited to the live-zero span. When a fault input asserts, the fault is latched. The highest-priority latched fault then replaces the request with a defined safe action: an alarm current, a frozen or held value, relays off and duty zero.

Every latched escalation emits a one-cycle event record for a logger. A power-restore event is emitted out of reset. The block also runs a quiet window. After any cycle in which the loop code or a relay bit changes, the sample-enable output stays low for a programmable number of cycles, so that measurement sampling does not overlap output transients. Leaving a fault needs both a clear fault input and an explicit clear pulse.

Top module: `failsafe_out_ctrl`

## Requirements
- R1: While reset is applied and in the first cycle after its release, loop_code_o is 720 (3.6 mA), relay_en_o and pwm_duty_o are 0, and sample_en_o is 1. evt_valid_o is 1 with evt_code_o 0 (power restore) in that period.
- R2: With no latched fault, each clock edge registers the request into the outputs. loop_code_o becomes req_code_i clamped to 800..4000 (4 mA..20 mA at 5 uA per code), pwm_duty_o becomes req_pwm_i and relay_en_o becomes req_relay_i.
- R3: A high fault input sets its latch at the next edge. The latch stays set until an edge where clear_fault_i is 1 and that fault input is 0. fault_state_o shows the highest latched class: 3 CRC failure, 2 controller fault, 1 probe fault, 0 none.
- R4: In any edge where fault_state_o is nonzero, relay_en_o and pwm_duty_o are loaded with 0.
- R5: In CRC state the loop code is loaded with the alarm code, and ctl_block_o is 1.
- R6: In controller-fault state the loop code is loaded with the last normal (clamped) code if ctrl_freeze_i is 1, otherwise with the alarm code.
- R7: In probe-fault state with probe_hold_i 1, the last normal code is loaded for the first HOLD_CYC (16) edges in that state, then the alarm code. With probe_hold_i 0 the alarm code is loaded at once.
- R8: The alarm code is 4200 (21 mA) when alarm_hi_i is 1 and 720 (3.6 mA) otherwise.
- R9: When fault_state_o rises to a higher class than in the previous cycle, evt_valid_o is 1 for that cycle and evt_code_o equals the new class.
- R10: After an edge that changes loop_code_o or any relay_en_o bit, sample_en_o is 0 for settle_len_i cycles. A further change restarts the count, and settle_len_i of 0 gives no inhibit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_code_i | input | CW (13) | Requested loop code in normal operation |
| req_pwm_i | input | PW (10) | Requested voltage/PWM duty |
| req_relay_i | input | NR (4) | Requested relay/SSR enables |
| probe_fault_i | input | 1 | Probe fault flag |
| ctrl_fault_i | input | 1 | Controller fault flag |
| crc_fault_i | input | 1 | Calibration record check failure flag |
| clear_fault_i | input | 1 | Clear pulse for latched faults |
| alarm_hi_i | input | 1 | Alarm current select: 1 high, 0 low |
| ctrl_freeze_i | input | 1 | Freeze last code on controller fault |
| probe_hold_i | input | 1 | Hold last code on probe fault until timeout |
| settle_len_i | input | SW (8) | Quiet window length in cycles |
| loop_code_o | output | CW (13) | Commanded loop code |
| pwm_duty_o | output | PW (10) | Commanded duty |
| relay_en_o | output | NR (4) | Commanded relay enables |
| ctl_block_o | output | 1 | Control loop blocked (CRC state) |
| sample_en_o | output | 1 | Measurement sampling allowed |
| fault_state_o | output | 2 | Active fault class |
| evt_valid_o | output | 1 | Event record valid |
| evt_code_o | output | 2 | Event class, 0 = power restore |

## Verification
A fault latch stuck set or lost shows at once on fault_state_o. A wrong output selection shows one cycle later on the loop code, the relays or the duty, because those outputs are registered. A hold timer that is off by some count moves the held-to-alarm transition on loop_code_o by the same number of edges. An escalation that is logged twice or missed shows as an extra or missing evt_valid_o cycle. A settle counter that loads or restarts wrongly moves the rising edge of sample_en_o by whole cycles. Since the bench model is compared on every clock, each of these shows in the first cycle where it departs from the expected value.

// File: rtl/fso_pkg.sv
package fso_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_PROBE  = 2'd1,
    ST_CTRL   = 2'd2,
    ST_CRC    = 2'd3
  } fso_state_e;

  localparam logic [1:0] EVT_PWR = 2'd0;
endpackage

// File: rtl/fso_fault_latch.sv
module fso_fault_latch
  import fso_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       probe_fault_i,
  input  logic       ctrl_fault_i,
  input  logic       crc_fault_i,
  input  logic       clear_fault_i,
  output fso_state_e state_o,
  output logic       evt_valid_o,
  output logic [1:0] evt_code_o
);
  localparam int NF = 3;

  logic [NF-1:0] flt;
  logic [NF-1:0] lat_q;
  fso_state_e    prev_q;
  logic          boot_q;

  assign flt = {crc_fault_i, ctrl_fault_i, probe_fault_i};

  // set wins over clear; clear only releases when the source is gone
  for (genvar i = 0; i < NF; i++) begin : g_lat
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lat_q[i] <= 1'b0;
      else         lat_q[i] <= flt[i] | (lat_q[i] & ~clear_fault_i);
    end
  end

  always_comb begin
    if (lat_q[2])      state_o = ST_CRC;
    else if (lat_q[1]) state_o = ST_CTRL;
    else if (lat_q[0]) state_o = ST_PROBE;
    else               state_o = ST_NORMAL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= ST_NORMAL;
      boot_q <= 1'b1;
    end else begin
      prev_q <= state_o;
      boot_q <= 1'b0;
    end
  end

  assign evt_valid_o = boot_q | (state_o > prev_q);
  assign evt_code_o  = boot_q ? EVT_PWR : state_o;
endmodule

// File: rtl/fso_out_sel.sv
module fso_out_sel
  import fso_pkg::*;
#(
  parameter int CW          = 13,
  parameter int PW          = 10,
  parameter int NR          = 4,
  parameter int HOLD_CYC    = 16,
  parameter int CODE_LO     = 800,
  parameter int CODE_HI     = 4000,
  parameter int CODE_ALM_LO = 720,
  parameter int CODE_ALM_HI = 4200
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  fso_state_e    state_i,
  input  logic [CW-1:0] req_code_i,
  input  logic [PW-1:0] req_pwm_i,
  input  logic [NR-1:0] req_relay_i,
  input  logic          alarm_hi_i,
  input  logic          ctrl_freeze_i,
  input  logic          probe_hold_i,
  output logic [CW-1:0] loop_o,
  output logic [PW-1:0] pwm_o,
  output logic [NR-1:0] relay_o,
  output logic          changed_o
);
  localparam int          TW   = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] C_LO = CW'(CODE_LO);
  localparam logic [CW-1:0] C_HI = CW'(CODE_HI);
  localparam logic [CW-1:0] A_LO = CW'(CODE_ALM_LO);
  localparam logic [CW-1:0] A_HI = CW'(CODE_ALM_HI);
  localparam logic [TW-1:0] T_MAX = TW'(HOLD_CYC);

  logic [CW-1:0] clamp_c, alarm_c, last_q, loop_d;
  logic [PW-1:0] pwm_d;
  logic [NR-1:0] relay_d;
  logic [TW-1:0] tmo_q;
  logic          hold_live;

  always_comb begin
    if (req_code_i < C_LO)      clamp_c = C_LO;
    else if (req_code_i > C_HI) clamp_c = C_HI;
    else                        clamp_c = req_code_i;
  end

  assign alarm_c   = alarm_hi_i ? A_HI : A_LO;
  assign hold_live = probe_hold_i && (tmo_q < T_MAX);

  always_comb begin
    pwm_d   = '0;
    relay_d = '0;
    unique case (state_i)
      ST_NORMAL: begin
        loop_d  = clamp_c;
        pwm_d   = req_pwm_i;
        relay_d = req_relay_i;
      end
      ST_PROBE: loop_d = hold_live ? last_q : alarm_c;
      ST_CTRL:  loop_d = ctrl_freeze_i ? last_q : alarm_c;
      default:  loop_d = alarm_c;
    endcase
  end

  assign changed_o = (loop_d != loop_o) || (relay_d != relay_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loop_o  <= A_LO;
      pwm_o   <= '0;
      relay_o <= '0;
      last_q  <= C_LO;
      tmo_q   <= '0;
    end else begin
      loop_o  <= loop_d;
      pwm_o   <= pwm_d;
      relay_o <= relay_d;
      if (state_i == ST_NORMAL) last_q <= clamp_c;
      if (state_i != ST_PROBE)  tmo_q  <= '0;
      else if (tmo_q < T_MAX)   tmo_q  <= tmo_q + 1'b1;
    end
  end
endmodule

// File: rtl/fso_quiet_win.sv
module fso_quiet_win #(
  parameter int SW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          changed_i,
  input  logic [SW-1:0] len_i,
  output logic          sample_en_o
);
  logic [SW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (changed_i)   cnt_q <= len_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign sample_en_o = (cnt_q == '0);
endmodule

// File: rtl/failsafe_out_ctrl.sv
module failsafe_out_ctrl
  import fso_pkg::*;
#(
  parameter int CW          = 13,
  parameter int PW          = 10,
  parameter int NR          = 4,
  parameter int SW          = 8,
  parameter int HOLD_CYC    = 16,
  parameter int CODE_LO     = 800,
  parameter int CODE_HI     = 4000,
  parameter int CODE_ALM_LO = 720,
  parameter int CODE_ALM_HI = 4200
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] req_code_i,
  input  logic [PW-1:0] req_pwm_i,
  input  logic [NR-1:0] req_relay_i,
  input  logic          probe_fault_i,
  input  logic          ctrl_fault_i,
  input  logic          crc_fault_i,
  input  logic          clear_fault_i,
  input  logic          alarm_hi_i,
  input  logic          ctrl_freeze_i,
  input  logic          probe_hold_i,
  input  logic [SW-1:0] settle_len_i,
  output logic [CW-1:0] loop_code_o,
  output logic [PW-1:0] pwm_duty_o,
  output logic [NR-1:0] relay_en_o,
  output logic          ctl_block_o,
  output logic          sample_en_o,
  output logic [1:0]    fault_state_o,
  output logic          evt_valid_o,
  output logic [1:0]    evt_code_o
);
  fso_state_e state;
  logic       changed;

  fso_fault_latch u_lat (
    .clk_i, .rst_ni, .probe_fault_i, .ctrl_fault_i, .crc_fault_i, .clear_fault_i,
    .state_o(state), .evt_valid_o, .evt_code_o
  );

  fso_out_sel #(
    .CW(CW), .PW(PW), .NR(NR), .HOLD_CYC(HOLD_CYC), .CODE_LO(CODE_LO),
    .CODE_HI(CODE_HI), .CODE_ALM_LO(CODE_ALM_LO), .CODE_ALM_HI(CODE_ALM_HI)
  ) u_sel (
    .clk_i, .rst_ni, .state_i(state), .req_code_i, .req_pwm_i, .req_relay_i,
    .alarm_hi_i, .ctrl_freeze_i, .probe_hold_i,
    .loop_o(loop_code_o), .pwm_o(pwm_duty_o), .relay_o(relay_en_o), .changed_o(changed)
  );

  fso_quiet_win #(.SW(SW)) u_qw (
    .clk_i, .rst_ni, .changed_i(changed), .len_i(settle_len_i), .sample_en_o
  );

  assign fault_state_o = state;
  assign ctl_block_o   = (state == ST_CRC);
endmodule

// File: rtl/fso_chk.sv
module fso_chk #(
  parameter int CW          = 13,
  parameter int PW          = 10,
  parameter int NR          = 4,
  parameter int SW          = 8,
  parameter int CODE_LO     = 800,
  parameter int CODE_HI     = 4000,
  parameter int CODE_ALM_LO = 720,
  parameter int CODE_ALM_HI = 4200
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          clear_fault_i,
  input logic [SW-1:0] settle_len_i,
  input logic [CW-1:0] loop_code_o,
  input logic [PW-1:0] pwm_duty_o,
  input logic [NR-1:0] relay_en_o,
  input logic          sample_en_o,
  input logic [1:0]    fault_state_o,
  input logic          evt_valid_o,
  input logic [1:0]    evt_code_o
);
  logic pv_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pv_q <= 1'b0;
    else         pv_q <= 1'b1;
  end

  a_r4_safe_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pv_q && $past(fault_state_o) != 2'd0 |-> relay_en_o == '0 && pwm_duty_o == '0);

  a_r2_live_zero_span: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pv_q && $past(fault_state_o) == 2'd0 |->
      loop_code_o >= CW'(CODE_LO) && loop_code_o <= CW'(CODE_HI));

  a_r5_crc_alarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pv_q && $past(fault_state_o) == 2'd3 |->
      loop_code_o == CW'(CODE_ALM_LO) || loop_code_o == CW'(CODE_ALM_HI));

  a_r3_no_auto_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pv_q && $past(fault_state_o) != 2'd0 && !$past(clear_fault_i) |->
      fault_state_o >= $past(fault_state_o));

  a_r9_single_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o && evt_code_o != 2'd0 |=> !evt_valid_o || evt_code_o > $past(evt_code_o));

  a_r10_quiet_after_relay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pv_q && relay_en_o != $past(relay_en_o) && $past(settle_len_i) != '0 |-> !sample_en_o);
endmodule

bind failsafe_out_ctrl fso_chk #(
  .CW(CW), .PW(PW), .NR(NR), .SW(SW), .CODE_LO(CODE_LO), .CODE_HI(CODE_HI),
  .CODE_ALM_LO(CODE_ALM_LO), .CODE_ALM_HI(CODE_ALM_HI)
) u_chk (.*);

// File: tb/sim_failsafe_out_ctrl.sv
`timescale 1ns/1ps
module sim_failsafe_out_ctrl;
  localparam int CW = 13, PW = 10, NR = 4, SW = 8, HOLD = 16;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0] req_code = '0;
  logic [PW-1:0] req_pwm = '0;
  logic [NR-1:0] req_relay = '0;
  logic          f_probe = 0, f_ctrl = 0, f_crc = 0, clr = 0;
  logic          alm_hi = 0, freeze = 0, hold = 0;
  logic [SW-1:0] settle = 8'd5;

  logic [CW-1:0] loop_code;
  logic [PW-1:0] pwm_duty;
  logic [NR-1:0] relay_en;
  logic          ctl_block, sample_en, evt_valid;
  logic [1:0]    fault_state, evt_code;

  failsafe_out_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_code_i(req_code), .req_pwm_i(req_pwm),
    .req_relay_i(req_relay), .probe_fault_i(f_probe), .ctrl_fault_i(f_ctrl),
    .crc_fault_i(f_crc), .clear_fault_i(clr), .alarm_hi_i(alm_hi),
    .ctrl_freeze_i(freeze), .probe_hold_i(hold), .settle_len_i(settle),
    .loop_code_o(loop_code), .pwm_duty_o(pwm_duty), .relay_en_o(relay_en),
    .ctl_block_o(ctl_block), .sample_en_o(sample_en), .fault_state_o(fault_state),
    .evt_valid_o(evt_valid), .evt_code_o(evt_code)
  );

  always #2.5 clk = ~clk;

  int vectors = 0, miscompares = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit [2:0] m_lat;
  int m_prev, m_last, m_tmo, m_loop, m_relay, m_pwm, m_cnt;
  bit m_boot;

  function automatic int prio(bit [2:0] l);
    if (l[2]) return 3;
    if (l[1]) return 2;
    if (l[0]) return 1;
    return 0;
  endfunction

  task automatic m_reset();
    m_lat = 0; m_prev = 0; m_last = 800; m_tmo = 0;
    m_loop = 720; m_relay = 0; m_pwm = 0; m_cnt = 0; m_boot = 1;
  endtask

  task automatic m_step();
    int st, cv, alm, ld, rd, pd;
    st  = prio(m_lat);
    cv  = int'(req_code) < 800 ? 800 : (int'(req_code) > 4000 ? 4000 : int'(req_code));
    alm = alm_hi ? 4200 : 720;
    rd = 0; pd = 0;
    case (st)
      0: begin ld = cv; rd = int'(req_relay); pd = int'(req_pwm); end
      1: ld = (hold && m_tmo < HOLD) ? m_last : alm;
      2: ld = freeze ? m_last : alm;
      default: ld = alm;
    endcase
    if (ld != m_loop || rd != m_relay) m_cnt = int'(settle);
    else if (m_cnt > 0) m_cnt = m_cnt - 1;
    if (st == 0) m_last = cv;
    m_tmo = (st == 1) ? ((m_tmo < HOLD) ? m_tmo + 1 : m_tmo) : 0;
    m_prev = st; m_boot = 0;
    m_lat = {f_crc, f_ctrl, f_probe} | (m_lat & ~{3{clr}});
    m_loop = ld; m_relay = rd; m_pwm = pd;
  endtask

  task automatic chk(string fld, int act, int exp, inout bit bad);
    if (act != exp) begin
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", cur_req, fld, act, exp, $time);
      bad = 1;
    end
  endtask

  task automatic compare();
    bit bad = 0;
    int st = prio(m_lat);
    bit ev = m_boot || (st > m_prev);
    chk("loop_code", int'(loop_code), m_loop, bad);
    chk("relay_en", int'(relay_en), m_relay, bad);
    chk("pwm_duty", int'(pwm_duty), m_pwm, bad);
    chk("fault_state", int'(fault_state), st, bad);
    chk("ctl_block", int'(ctl_block), int'(st == 3), bad);
    chk("sample_en", int'(sample_en), int'(m_cnt == 0), bad);
    chk("evt_valid", int'(evt_valid), int'(ev), bad);
    if (ev) chk("evt_code", int'(evt_code), m_boot ? 0 : st, bad);
    vectors++;
    if (bad) miscompares++;
  endtask

  initial m_reset();

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else m_step();
    #1 compare();
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr();
    clr = 1; cyc(1); clr = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #500000;
    $display("FAIL watchdog expired");
    miscompares++;
    finish_run();
  end

  initial begin
    cur_req = "R1";                       // reset state and power restore event
    cyc(4);
    rst_n = 1;
    cyc(2);

    cur_req = "R2";                       // clamp low, mid, high; duty and relays pass
    req_code = 13'd100; req_pwm = 10'd300; req_relay = 4'b0101; cyc(10);
    req_code = 13'd2000; req_pwm = 10'd512; cyc(10);
    req_code = 13'd5000; req_relay = 4'b1010; cyc(10);
    req_code = 13'd2000; cyc(10);

    cur_req = "R10";                      // back-to-back relay changes restart window
    req_relay = 4'b0001; cyc(2);
    req_relay = 4'b0011; cyc(3);
    req_relay = 4'b0111; cyc(8);
    settle = 8'd0; req_relay = 4'b1111; cyc(3);
    settle = 8'd5; req_relay = 4'b0110; cyc(8);

    cur_req = "R7";                       // probe fault, no hold, low alarm (R8)
    hold = 0; alm_hi = 0; f_probe = 1; cyc(6);
    cur_req = "R3";                       // clear ignored while source still set
    pulse_clr(); cyc(3);
    f_probe = 0; cyc(4);                  // latched, no auto return
    pulse_clr(); cyc(10);

    cur_req = "R8";                       // probe hold then high alarm after timeout
    req_code = 13'd2500; cyc(8);
    hold = 1; alm_hi = 1; f_probe = 1; cyc(HOLD + 8);
    f_probe = 0; pulse_clr(); cyc(10);

    cur_req = "R6";                       // controller fault, freeze then alarm
    req_code = 13'd3000; cyc(8);
    freeze = 1; f_ctrl = 1; cyc(8);
    freeze = 0; cyc(8);

    cur_req = "R9";                       // escalation to CRC logs an event
    f_probe = 1; cyc(3);                  // lower class: no event
    f_crc = 1; cyc(3);
    cur_req = "R5";
    f_crc = 0; cyc(5);
    cur_req = "R4";
    req_relay = 4'b1111; req_pwm = 10'd1000; cyc(5);
    f_probe = 0; f_ctrl = 0; pulse_clr(); cyc(10);

    cur_req = "R3";                       // simultaneous faults pick highest
    f_probe = 1; f_ctrl = 1; cyc(4);
    f_probe = 0; f_ctrl = 0; pulse_clr(); cyc(10);

    finish_run();
  end
endmodule